// File: doc/BRIEF.md
# Effective Address Generator

This block forms the memory address for a load/store pipeline from operand fields that have already been decoded. A three-bit mode code selects how the address is built. It can be a bare immediate, the base register, the base plus a displacement, the program counter plus a signed displacement, or the base plus a second register that has passed through a shift stage. For the two base-plus-offset modes, an index form code selects one of three results. The base can stay unchanged. The sum can both drive the access and update the base. Or the access can use the old base while the sum goes to the base register afterward.

All results are registered. An input strobe acts as the clock enable, and a valid flag follows it one cycle later. The register file, memory access and instruction decode are outside this block. The block only reports the address to use, the value to write back to the base register, and whether that writeback should happen.

Top module: `eag_top`

## Requirements
- R1: While rst_n is low, out_valid, ea, wb_addr and wb_en are all zero.
- R2: Outputs change only on a rising edge where in_valid is high, and they appear one cycle after that edge. out_valid is in_valid delayed by one cycle. While in_valid is low, ea, wb_addr and wb_en hold their values.
- R3: With mode 0 (direct), and with the unused mode codes 5 to 7, ea is the extended immediate and wb_en is 0.
- R4: The 12-bit immediate is sign-extended to 32 bits when sext_en is 1 and zero-extended when sext_en is 0. This applies in modes 0 and 2.
- R5: With mode 1 (register indirect), ea equals base_val.
- R6: With mode 2 (base plus displacement), the sum is base_val plus the extended immediate.
- R7: With mode 3 (PC-relative), ea is pc_val plus the sign-extended immediate, so backward targets are possible. sext_en and sub_en have no effect in this mode.
- R8: With mode 4 (scaled index), the offset is off_reg after a shift chosen by sh_type, using the amount sh_amt. The codes are 0 shift left, 1 logical shift right, 2 arithmetic shift right and 3 rotate right. Code 4 is a one-bit rotate right through carry_in, with carry_in entering at bit 31, and it ignores sh_amt. Codes 5 to 7 pass off_reg unshifted.
- R9: In modes 2 and 4, sub_en set to 1 subtracts the offset from base_val instead of adding it. The result wraps modulo 2^32.
- R10: In modes 2 and 4, index form 0 or 3 (plain offset) makes ea the sum, with wb_en 0 and wb_addr 0.
- R11: In modes 2 and 4, index form 1 (preindex) makes both ea and wb_addr the sum, with wb_en 1.
- R12: In modes 2 and 4, index form 2 (postindex) makes ea the unmodified base_val and wb_addr the sum, with wb_en 1.
- R13: In modes 0, 1, 3 and 5 to 7, the form code is ignored: wb_en is 0 and wb_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand fields valid; enables the output registers |
| mode | input | 3 | Addressing mode code |
| form | input | 2 | Index form: 0/3 offset, 1 preindex, 2 postindex |
| sub_en | input | 1 | Subtract offset from base when 1 |
| sext_en | input | 1 | Sign-extend the immediate when 1 |
| imm_field | input | 12 | Immediate address or displacement field |
| base_val | input | 32 | Base register content |
| off_reg | input | 32 | Offset register content for mode 4 |
| sh_type | input | 3 | Offset shift kind |
| sh_amt | input | 5 | Offset shift amount |
| carry_in | input | 1 | Carry bit for rotate through carry |
| pc_val | input | 32 | Program counter |
| out_valid | output | 1 | Registered result valid |
| ea | output | 32 | Effective address for the access |
| wb_addr | output | 32 | Value to write back to the base register |
| wb_en | output | 1 | Base writeback request |

## Verification
The output registers hold only the last accepted operation. A wrong address, shift or form decode therefore shows on ea, wb_addr or wb_en exactly one cycle after the offending strobe, and the sweep catches it at the first mismatch. A wrongly enabled hold path shows as outputs that change during idle cycles. A shift fault with the wrong amount or fill bit shows only for certain amounts, so all 32 amounts are swept for every shift kind. Form faults show as base-versus-sum swaps on ea, or as a stray wb_en in the non-indexing modes.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 12;

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_REGIND   = 3'd1,
    AM_BASEDISP = 3'd2,
    AM_PCREL    = 3'd3,
    AM_INDEXED  = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    IX_OFFSET = 2'd0,
    IX_PRE    = 2'd1,
    IX_POST   = 2'd2,
    IX_OFF2   = 2'd3
  } ixform_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shkind_e;
endpackage

// File: rtl/eag_imm_ext.sv
module eag_imm_ext #(
  parameter int unsigned IMM_W  = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sext,
  output logic [DATA_W-1:0] ext
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (sext) ext = {{PAD_W{imm[IMM_W-1]}}, imm};
    else      ext = {{PAD_W{1'b0}}, imm};
  end

  // R4
  always_comb begin
    if (!sext) zext_upper_chk: assert (ext[DATA_W-1:IMM_W] == '0);
  end
endmodule

// File: rtl/eag_shifter.sv
module eag_shifter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]         x,
  input  logic [2:0]                kind,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  logic                      carry_in,
  output logic [DATA_W-1:0]         y
);
  import eag_pkg::*;

  logic [DATA_W-1:0] lsl_v, lsr_v, asr_v, ror_v, rrx_v;

  always_comb begin
    lsl_v = x << amt;
    lsr_v = x >> amt;
    asr_v = DATA_W'($signed(x) >>> amt);
    ror_v = (x >> amt) | (x << (DATA_W - amt));
    rrx_v = {carry_in, x[DATA_W-1:1]};
  end

  always_comb begin
    case (kind)
      SH_LSL:  y = lsl_v;
      SH_LSR:  y = lsr_v;
      SH_ASR:  y = asr_v;
      SH_ROR:  y = ror_v;
      SH_RRX:  y = rrx_v;
      default: y = x;
    endcase
  end

  // R8
  always_comb begin
    if (kind == SH_RRX) rrx_fill_chk: assert (y[DATA_W-1] == carry_in);
  end
endmodule

// File: rtl/eag_addsub.sv
module eag_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end

  // R9
  always_comb begin
    if (sub) sub_inverse_chk: assert (DATA_W'(y + b) == a);
  end
endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int unsigned DATA_W = eag_pkg::DATA_W,
  parameter int unsigned IMM_W  = eag_pkg::IMM_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2:0]                mode,
  input  logic [1:0]                form,
  input  logic                      sub_en,
  input  logic                      sext_en,
  input  logic [IMM_W-1:0]          imm_field,
  input  logic [DATA_W-1:0]         base_val,
  input  logic [DATA_W-1:0]         off_reg,
  input  logic [2:0]                sh_type,
  input  logic [$clog2(DATA_W)-1:0] sh_amt,
  input  logic                      carry_in,
  input  logic [DATA_W-1:0]         pc_val,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         ea,
  output logic [DATA_W-1:0]         wb_addr,
  output logic                      wb_en
);
  import eag_pkg::*;

  logic [DATA_W-1:0] imm_x, imm_pc, shifted, offset, idx_sum, pc_sum;
  logic [DATA_W-1:0] ea_n, wb_addr_n;
  logic              wb_en_n;
  logic              idx_mode;

  eag_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext_main (
    .imm(imm_field), .sext(sext_en), .ext(imm_x)
  );

  eag_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext_pc (
    .imm(imm_field), .sext(1'b1), .ext(imm_pc)
  );

  eag_shifter #(.DATA_W(DATA_W)) u_shift (
    .x(off_reg), .kind(sh_type), .amt(sh_amt), .carry_in(carry_in), .y(shifted)
  );

  eag_addsub #(.DATA_W(DATA_W)) u_idx_add (
    .a(base_val), .b(offset), .sub(sub_en), .y(idx_sum)
  );

  eag_addsub #(.DATA_W(DATA_W)) u_pc_add (
    .a(pc_val), .b(imm_pc), .sub(1'b0), .y(pc_sum)
  );

  always_comb begin
    offset   = (mode == AM_INDEXED) ? shifted : imm_x;
    idx_mode = (mode == AM_BASEDISP) || (mode == AM_INDEXED);
  end

  // next-state
  always_comb begin
    ea_n      = imm_x;
    wb_addr_n = '0;
    wb_en_n   = 1'b0;
    if (idx_mode) begin
      case (form)
        IX_PRE: begin
          ea_n      = idx_sum;
          wb_addr_n = idx_sum;
          wb_en_n   = 1'b1;
        end
        IX_POST: begin
          ea_n      = base_val;
          wb_addr_n = idx_sum;
          wb_en_n   = 1'b1;
        end
        default: ea_n = idx_sum;
      endcase
    end else begin
      case (mode)
        AM_REGIND: ea_n = base_val;
        AM_PCREL:  ea_n = pc_sum;
        default:   ea_n = imm_x;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea      <= '0;
      wb_addr <= '0;
      wb_en   <= 1'b0;
    end else if (in_valid) begin
      ea      <= ea_n;
      wb_addr <= wb_addr_n;
      wb_en   <= wb_en_n;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(wb_addr) && $stable(wb_en)));

  // R12
  post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == AM_BASEDISP || mode == AM_INDEXED) && form == IX_POST)
    |=> (wb_en && ea == $past(base_val)));

  // R13
  no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(mode == AM_BASEDISP || mode == AM_INDEXED))
    |=> (!wb_en && wb_addr == '0));
endmodule

// File: tb/eag_top_test.sv
module eag_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [1:0]  form;
  logic        sub_en, sext_en;
  logic [11:0] imm_field;
  logic [31:0] base_val, off_reg, pc_val;
  logic [2:0]  sh_type;
  logic [4:0]  sh_amt;
  logic        carry_in;
  logic        out_valid, wb_en;
  logic [31:0] ea, wb_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eag_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .form(form),
    .sub_en(sub_en), .sext_en(sext_en), .imm_field(imm_field),
    .base_val(base_val), .off_reg(off_reg), .sh_type(sh_type), .sh_amt(sh_amt),
    .carry_in(carry_in), .pc_val(pc_val), .out_valid(out_valid), .ea(ea),
    .wb_addr(wb_addr), .wb_en(wb_en)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      report();
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ext_m(logic [11:0] v, logic s);
    if (s && v[11]) return 32'hFFFFF000 + 32'(v);
    return 32'(v);
  endfunction

  function automatic logic [31:0] shift_m(logic [31:0] x, logic [2:0] t, int n, logic c);
    logic [31:0] r = x;
    case (t)
      3'd0: for (int i = 0; i < n; i++) r = r * 2;
      3'd1: for (int i = 0; i < n; i++) r = r / 2;
      3'd2: for (int i = 0; i < n; i++) r = (r / 2) | (r & 32'h80000000);
      3'd3: for (int i = 0; i < n; i++) r = (r / 2) | (r[0] ? 32'h80000000 : 32'h0);
      3'd4: r = (x / 2) | (c ? 32'h80000000 : 32'h0);
      default: r = x;
    endcase
    return r;
  endfunction

  task automatic run_op(logic [2:0] m, logic [1:0] f, logic s, logic sx,
                        logic [11:0] im, logic [31:0] b, logic [31:0] o,
                        logic [2:0] st, logic [4:0] sa, logic c, logic [31:0] p);
    logic [31:0] off, sum, e_ea, e_wb;
    logic e_en;
    string tg, tw;
    @(negedge clk);
    in_valid = 1; mode = m; form = f; sub_en = s; sext_en = sx; imm_field = im;
    base_val = b; off_reg = o; sh_type = st; sh_amt = sa; carry_in = c; pc_val = p;
    off = (m == 3'd4) ? shift_m(o, st, int'(sa), c) : ext_m(im, sx);
    sum = s ? b - off : b + off;
    e_wb = 0; e_en = 0; tw = "R13";
    case (m)
      3'd1: begin e_ea = b; tg = "R5"; end
      3'd3: begin e_ea = p + ext_m(im, 1'b1); tg = "R7"; end
      3'd2, 3'd4: begin
        tg = s ? "R9" : ((m == 3'd2) ? "R6" : "R8");
        if (f == 2'd1)      begin e_ea = sum; e_wb = sum; e_en = 1; tw = "R11"; end
        else if (f == 2'd2) begin e_ea = b;   e_wb = sum; e_en = 1; tw = "R12"; end
        else                begin e_ea = sum; tw = "R10"; end
      end
      default: begin e_ea = ext_m(im, sx); tg = sx ? "R4" : "R3"; end
    endcase
    @(negedge clk);
    in_valid = 0;
    check({tg, " ea"}, ea, e_ea);
    check({tw, " wb_addr"}, wb_addr, e_wb);
    check({tw, " wb_en"}, {31'b0, wb_en}, {31'b0, e_en});
    check("R2 out_valid", {31'b0, out_valid}, 32'd1);
  endtask

  initial begin
    logic [31:0] vals [4];
    logic [31:0] hold_ea, hold_wb;
    logic hold_en;
    vals[0] = 32'h8000_0001; vals[1] = 32'h1234_5678;
    vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h0000_0000;
    rst_n = 0; in_valid = 0; mode = 0; form = 0; sub_en = 0; sext_en = 0;
    imm_field = 0; base_val = 0; off_reg = 0; sh_type = 0; sh_amt = 0;
    carry_in = 0; pc_val = 0;
    repeat (2) @(negedge clk);
    in_valid = 1; base_val = 32'hDEAD_BEEF; mode = 3'd1;
    @(negedge clk);
    // R1: reset holds everything at zero even with a strobe present
    check("R1 out_valid", {31'b0, out_valid}, 0);
    check("R1 ea", ea, 0);
    check("R1 wb_addr", wb_addr, 0);
    check("R1 wb_en", {31'b0, wb_en}, 0);
    in_valid = 0;
    rst_n = 1;
    @(negedge clk);
    check("R2 idle out_valid", {31'b0, out_valid}, 0);

    // R8 shift sweep: every kind, every amount, several patterns
    for (int t = 0; t < 8; t++)
      for (int a = 0; a < 32; a++)
        for (int v = 0; v < 3; v++)
          run_op(3'd4, 2'd0, 1'b0, 1'b0, 12'h0, 32'h0100_0000, vals[v],
                 3'(t), 5'(a), 1'(a & 1), 32'h0);

    // R3 R4 R5 R6 R7 R9 R10 R11 R12 R13: mode x form x sub x sext sweep
    for (int m = 0; m < 8; m++)
      for (int f = 0; f < 4; f++)
        for (int s = 0; s < 2; s++)
          for (int x = 0; x < 2; x++) begin
            run_op(3'(m), 2'(f), 1'(s), 1'(x), 12'h804, vals[1], 32'h0000_0010,
                   3'd0, 5'd2, 1'b0, 32'h0000_4000);
            run_op(3'(m), 2'(f), 1'(s), 1'(x), 12'h7FF, vals[0], 32'h8000_0000,
                   3'd2, 5'd4, 1'b1, 32'h0000_0100);
          end

    // R7: backward reference that wraps below zero
    run_op(3'd3, 2'd1, 1'b1, 1'b0, 12'hFF0, 32'h0, 32'h0, 3'd0, 5'd0, 1'b0, 32'h0000_0008);
    // R9: subtraction that wraps
    run_op(3'd2, 2'd1, 1'b1, 1'b0, 12'h010, 32'h0000_0004, 32'h0, 3'd0, 5'd0, 1'b0, 32'h0);

    // R2: idle cycles with changed inputs leave the outputs alone
    run_op(3'd4, 2'd2, 1'b0, 1'b0, 12'h0, 32'h1111_0000, 32'h3, 3'd0, 5'd3, 1'b0, 32'h0);
    hold_ea = ea; hold_wb = wb_addr; hold_en = wb_en;
    mode = 3'd3; form = 2'd1; base_val = 32'h5555_5555; pc_val = 32'h7777_0000;
    repeat (3) @(negedge clk);
    check("R2 hold ea", ea, hold_ea);
    check("R2 hold wb_addr", wb_addr, hold_wb);
    check("R2 hold wb_en", {31'b0, wb_en}, {31'b0, hold_en});
    check("R2 valid drop", {31'b0, out_valid}, 0);

    done = 1;
    report();
    $finish;
  end
endmodule